// File: doc/BRIEF.md
# Zero-Operand Stack Execution Unit

This block runs a stream of stack-machine instructions handed to it one at a time over a valid/ready handshake. It holds an operand stack of eight 16-bit entries and a small word-addressed data memory. Only two instructions touch memory, and each names one word: a push reads that word onto the stack and a pop moves the top entry into it. The arithmetic instructions name no operands. They always take the two topmost entries and replace them with one result.

Every accepted instruction takes effect at the clock edge that accepts it. Three sticky flags report a push onto a full stack, an instruction that needed more entries than the stack held, and a halt. A debug port reads any memory word combinationally and can write one, so that a host can load operands and collect results. A postfix program such as the one for X*Y + W*U therefore runs as pushes, operations and a final pop.

Top module: `stack_exec_unit`

## Requirements
- R1: A synchronous reset with `rst` high empties the stack and clears all three flags, and `instr_ready` is high after reset. Reset does not change the data memory.
- R2: An accepted instruction with `instr_op` = 3'b000 (push) reads memory word `instr_addr` and places it on top of the stack, which grows by one entry.
- R3: An accepted instruction with `instr_op` = 3'b001 (pop) writes the top entry to memory word `instr_addr` and removes it from the stack.
- R4: `instr_op` = 3'b010 (add) replaces the two top entries with their sum modulo 2^16, so the stack shrinks by one entry.
- R5: `instr_op` = 3'b011 (subtract) replaces the two top entries with the entry below the top minus the top entry, modulo 2^16.
- R6: `instr_op` = 3'b100 (multiply) replaces the two top entries with the low 16 bits of their product.
- R7: A push while the stack holds 8 entries sets `flag_overflow`, which stays set until reset, and leaves the stack unchanged.
- R8: A pop on an empty stack, or an add, subtract or multiply with fewer than two entries, sets `flag_underflow`, which stays set until reset, and leaves both the stack and the memory unchanged.
- R9: `instr_op` = 3'b111 (halt) sets `flag_halt` and drops `instr_ready` until reset, and instructions offered while halted have no effect.
- R10: When `dbg_we` is high at a clock edge, `dbg_wdata` is written to word `dbg_addr`, and `dbg_rdata` always shows word `dbg_addr` without delay. A pop that writes the same word at the same edge wins over the debug write.
- R11: The codes 3'b101 and 3'b110 are accepted and have no effect on the stack, the memory or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | The unit accepts an instruction; low once halted |
| instr_op | input | 3 | Operation code |
| instr_addr | input | AW (4) | Memory word for push and pop |
| dbg_we | input | 1 | Debug write strobe |
| dbg_addr | input | AW (4) | Debug read and write address |
| dbg_wdata | input | DW (16) | Debug write data |
| dbg_rdata | output | DW (16) | Memory word at dbg_addr |
| flag_overflow | output | 1 | Sticky: push onto a full stack |
| flag_underflow | output | 1 | Sticky: too few stack entries |
| flag_halt | output | 1 | Halt was executed |

## Verification
On every cycle the assertions check the depth bookkeeping: the depth never goes above eight, a push that fits adds exactly one entry, an operation on two entries removes exactly one, and the depth stays put when no instruction is accepted or the unit has halted. They also check that all three flags stay set until reset, that overflow rises only after a push onto a full stack, and that underflow rises only when the depth does not move. The values need the bench's scenarios: it checks operand order for subtract, the truncated product and the wrapped sum by reading results back through the debug port. It shows refused operations as untouched stack contents and memory words, and it shows a pop winning over a debug write to the same word.

// File: rtl/stack_exec_unit.sv
module stack_exec_unit #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_valid,
  output logic          instr_ready,
  input  logic [2:0]    instr_op,
  input  logic [AW-1:0] instr_addr,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_addr,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata,
  output logic          flag_overflow,
  output logic          flag_underflow,
  output logic          flag_halt
);
  localparam int WORDS = 1 << AW;
  localparam int SPW   = $clog2(DEPTH + 1);
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  localparam logic [2:0] OP_PUSH = 3'b000;
  localparam logic [2:0] OP_POP  = 3'b001;
  localparam logic [2:0] OP_ADD  = 3'b010;
  localparam logic [2:0] OP_SUB  = 3'b011;
  localparam logic [2:0] OP_MUL  = 3'b100;
  localparam logic [2:0] OP_HALT = 3'b111;

  logic [DW-1:0]  stk [DEPTH];
  logic [DW-1:0]  mem [WORDS];
  logic [SPW-1:0] sp;
  logic           ovf_q, udf_q, halt_q;

  logic fire;
  logic is_push, is_pop, is_bin, is_halt;
  logic full, has1, has2;
  logic push_ok, pop_ok, bin_ok;
  logic [IW-1:0] idx_new, idx_top, idx_nxt;
  logic [DW-1:0] tos, nos, alu;
  logic [2*DW-1:0] prod;

  assign instr_ready = !halt_q;
  assign fire        = instr_valid && instr_ready;

  assign is_push = instr_op == OP_PUSH;
  assign is_pop  = instr_op == OP_POP;
  assign is_bin  = (instr_op == OP_ADD) || (instr_op == OP_SUB) || (instr_op == OP_MUL);
  assign is_halt = instr_op == OP_HALT;

  assign full = sp == SPW'(DEPTH);
  assign has1 = sp != '0;
  assign has2 = sp >= SPW'(2);

  assign push_ok = fire && is_push && !full;
  assign pop_ok  = fire && is_pop  && has1;
  assign bin_ok  = fire && is_bin  && has2;

  assign idx_new = IW'(sp);
  assign idx_top = IW'(sp - SPW'(1));
  assign idx_nxt = IW'(sp - SPW'(2));

  assign tos  = stk[idx_top];
  assign nos  = stk[idx_nxt];
  assign prod = nos * tos;

  always_comb begin
    case (instr_op)
      OP_ADD:  alu = nos + tos;
      OP_SUB:  alu = nos - tos;
      default: alu = prod[DW-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (push_ok) stk[idx_new] <= mem[instr_addr];
    if (bin_ok)  stk[idx_nxt] <= alu;
  end

  always_ff @(posedge clk) begin
    if (rst)                  sp <= '0;
    else if (push_ok)         sp <= sp + SPW'(1);
    else if (pop_ok || bin_ok) sp <= sp - SPW'(1);
  end

  always_ff @(posedge clk) begin
    if (dbg_we) mem[dbg_addr]   <= dbg_wdata;
    if (pop_ok) mem[instr_addr] <= tos;
  end

  assign dbg_rdata = mem[dbg_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (fire && is_push && full)                        ovf_q  <= 1'b1;
      if (fire && ((is_pop && !has1) || (is_bin && !has2))) udf_q <= 1'b1;
      if (fire && is_halt)                                halt_q <= 1'b1;
    end
  end

  assign flag_overflow  = ovf_q;
  assign flag_underflow = udf_q;
  assign flag_halt      = halt_q;
endmodule

// File: rtl/stack_exec_unit_chk.sv
module stack_exec_unit_chk #(
  parameter int DEPTH = 8,
  parameter int SPW   = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           instr_valid,
  input logic           instr_ready,
  input logic [2:0]     instr_op,
  input logic [SPW-1:0] sp,
  input logic           flag_overflow,
  input logic           flag_underflow,
  input logic           flag_halt
);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    sp <= SPW'(DEPTH));

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_overflow |=> flag_overflow);

  // R7
  overflow_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_overflow) |-> $past(instr_valid && instr_ready && instr_op == 3'b000 && sp == SPW'(DEPTH)));

  // R8
  underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_underflow |=> flag_underflow);

  // R8
  underflow_depth_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_underflow) |-> $stable(sp));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_halt |=> flag_halt);

  // R9
  halt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    flag_halt |=> $stable(sp));

  // R2
  push_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready && instr_op == 3'b000 && sp < SPW'(DEPTH)) |=> sp == $past(sp) + SPW'(1));

  // R4
  binop_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_ready && (instr_op == 3'b010 || instr_op == 3'b011 || instr_op == 3'b100)
     && sp >= SPW'(2)) |=> sp == $past(sp) - SPW'(1));

  // R11
  idle_depth_chk: assert property (@(posedge clk) disable iff (rst)
    !(instr_valid && instr_ready) |=> $stable(sp));
endmodule

bind stack_exec_unit stack_exec_unit_chk #(.DEPTH(DEPTH), .SPW(SPW)) u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
  .instr_op(instr_op), .sp(sp), .flag_overflow(flag_overflow),
  .flag_underflow(flag_underflow), .flag_halt(flag_halt)
);

// File: tb/stack_exec_unit_bench.sv
`timescale 1ns/1ps
module stack_exec_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic        instr_ready;
  logic [2:0]  instr_op = 3'b000;
  logic [3:0]  instr_addr = 4'd0;
  logic        dbg_we = 1'b0;
  logic [3:0]  dbg_addr = 4'd0;
  logic [15:0] dbg_wdata = 16'h0;
  logic [15:0] dbg_rdata;
  logic        flag_overflow, flag_underflow, flag_halt;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  stack_exec_unit u_stack_exec_unit (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_ready(instr_ready),
    .instr_op(instr_op), .instr_addr(instr_addr), .dbg_we(dbg_we),
    .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .flag_overflow(flag_overflow), .flag_underflow(flag_underflow),
    .flag_halt(flag_halt)
  );

  localparam logic [2:0] PU = 3'b000, PO = 3'b001, AD = 3'b010, SU = 3'b011, MU = 3'b100, HL = 3'b111;

  // {req, op, addr, check, expected word at addr after the instruction}
  localparam logic [27:0] PROG [24] = '{
    {4'd6, PU, 4'd0,  1'b0, 16'h0000},
    {4'd6, PU, 4'd1,  1'b0, 16'h0000},
    {4'd6, MU, 4'd0,  1'b0, 16'h0000},
    {4'd6, PU, 4'd2,  1'b0, 16'h0000},
    {4'd6, PU, 4'd3,  1'b0, 16'h0000},
    {4'd6, MU, 4'd0,  1'b0, 16'h0000},
    {4'd4, AD, 4'd0,  1'b0, 16'h0000},
    {4'd4, PO, 4'd8,  1'b1, 16'h005C},
    {4'd5, PU, 4'd1,  1'b0, 16'h0000},
    {4'd5, PU, 4'd0,  1'b0, 16'h0000},
    {4'd5, SU, 4'd0,  1'b0, 16'h0000},
    {4'd5, PO, 4'd9,  1'b1, 16'h0002},
    {4'd5, PU, 4'd0,  1'b0, 16'h0000},
    {4'd5, PU, 4'd1,  1'b0, 16'h0000},
    {4'd5, SU, 4'd0,  1'b0, 16'h0000},
    {4'd5, PO, 4'd10, 1'b1, 16'hFFFE},
    {4'd6, PU, 4'd4,  1'b0, 16'h0000},
    {4'd6, PU, 4'd5,  1'b0, 16'h0000},
    {4'd6, MU, 4'd0,  1'b0, 16'h0000},
    {4'd6, PO, 4'd11, 1'b1, 16'h3400},
    {4'd4, PU, 4'd6,  1'b0, 16'h0000},
    {4'd4, PU, 4'd7,  1'b0, 16'h0000},
    {4'd4, AD, 4'd0,  1'b0, 16'h0000},
    {4'd4, PO, 4'd12, 1'b1, 16'h0001}
  };

  function automatic string req_name(int n);
    case (n)
      4: return "R4 add";
      5: return "R5 subtract";
      6: return "R6 multiply";
      default: return "R3 pop";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic issue(logic [2:0] op, logic [3:0] addr);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_op = op;
    instr_addr = addr;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic dwrite(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    dbg_we = 1'b1;
    dbg_addr = a;
    dbg_wdata = d;
    @(negedge clk);
    dbg_we = 1'b0;
  endtask

  task automatic dread(logic [3:0] a, output logic [15:0] d);
    dbg_addr = a;
    #1;
    d = dbg_rdata;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] rd;
    do_reset();
    // R1 reset state
    check("R1 ready", {15'd0, instr_ready}, 16'd1);
    check("R1 flags", {13'd0, flag_overflow, flag_underflow, flag_halt}, 16'd0);

    dwrite(4'd0, 16'd3);
    dwrite(4'd1, 16'd5);
    dwrite(4'd2, 16'd7);
    dwrite(4'd3, 16'd11);
    dwrite(4'd4, 16'h1234);
    dwrite(4'd5, 16'h0100);
    dwrite(4'd6, 16'hFFFF);
    dwrite(4'd7, 16'h0002);
    dwrite(4'd13, 16'hAAAA);
    dread(4'd4, rd);
    check("R10 debug write/read", rd, 16'h1234);

    for (int i = 0; i < 24; i++) begin
      issue(PROG[i][23:21], PROG[i][20:17]);
      if (PROG[i][16]) begin
        dread(PROG[i][20:17], rd);
        check(req_name(int'(PROG[i][27:24])), rd, PROG[i][15:0]);
      end
    end

    // R2 R3: program leaves an empty stack, so a further pop underflows
    issue(PO, 4'd13);
    check("R8 pop on empty flag", {15'd0, flag_underflow}, 16'd1);
    dread(4'd13, rd);
    check("R8 pop on empty leaves memory", rd, 16'hAAAA);
    check("R8 no overflow", {15'd0, flag_overflow}, 16'd0);

    // R1 reset clears flags, keeps memory
    do_reset();
    check("R1 underflow cleared", {15'd0, flag_underflow}, 16'd0);
    dread(4'd8, rd);
    check("R1 memory kept", rd, 16'h005C);

    // R8 binary op with one entry leaves the stack intact
    issue(PU, 4'd0);
    issue(AD, 4'd0);
    check("R8 add with one entry flag", {15'd0, flag_underflow}, 16'd1);
    issue(PO, 4'd14);
    dread(4'd14, rd);
    check("R8 add with one entry keeps stack", rd, 16'd3);

    // R7 overflow
    do_reset();
    for (int i = 0; i < 8; i++) issue(PU, 4'(i));
    check("R7 eight pushes fit", {15'd0, flag_overflow}, 16'd0);
    issue(PU, 4'd8);
    check("R7 ninth push flag", {15'd0, flag_overflow}, 16'd1);
    issue(PO, 4'd15);
    dread(4'd15, rd);
    check("R7 ninth push ignored", rd, 16'h0002);
    check("R7 overflow sticky", {15'd0, flag_overflow}, 16'd1);

    // R11 unlisted codes
    do_reset();
    issue(PU, 4'd0);
    issue(3'b101, 4'd0);
    issue(3'b110, 4'd0);
    check("R11 flags untouched", {13'd0, flag_overflow, flag_underflow, flag_halt}, 16'd0);
    issue(PO, 4'd14);
    dread(4'd14, rd);
    check("R11 stack untouched", rd, 16'd3);
    check("R11 no underflow", {15'd0, flag_underflow}, 16'd0);

    // R10 pop wins over debug write to the same word
    issue(PU, 4'd1);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_op = PO;
    instr_addr = 4'd14;
    dbg_we = 1'b1;
    dbg_addr = 4'd14;
    dbg_wdata = 16'h5555;
    @(negedge clk);
    instr_valid = 1'b0;
    dbg_we = 1'b0;
    dread(4'd14, rd);
    check("R10 pop wins collision", rd, 16'd5);

    // R9 halt
    dwrite(4'd15, 16'h0BAD);
    issue(PU, 4'd2);
    issue(HL, 4'd0);
    check("R9 halt flag", {15'd0, flag_halt}, 16'd1);
    check("R9 ready low", {15'd0, instr_ready}, 16'd0);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_op = PO;
    instr_addr = 4'd15;
    repeat (3) @(negedge clk);
    instr_valid = 1'b0;
    dread(4'd15, rd);
    check("R9 pop while halted ignored", rd, 16'h0BAD);
    check("R9 still halted", {15'd0, flag_halt}, 16'd1);
    do_reset();
    check("R9 reset releases halt", {14'd0, flag_halt, instr_ready}, 16'd1);

    done = 1'b1;
    finish_run();
  end
endmodule